// File: doc/BRIEF.md
# LPC Host Memory Cycle Engine

This block is the host side of single-byte memory reads and writes on a Low Pin Count bus. A client pulses a start strobe with a direction flag, a 32-bit address and, for writes, a data byte. The engine then runs the whole bus sequence on the active-low frame strobe and the 4-bit multiplexed nibble lines. The nibble lines are split into an output, an output enable and an input, so a pad or a bus model can merge them.

The engine sends a start nibble, a cycle-type nibble, the address and any write data. It hands the bus to the target with a two-cycle turnaround and accepts any number of wait states. For a read it collects the returned byte, and it then gives the target two cycles to hand the bus back. Completion is reported by a one-clock done pulse, which carries an error flag and, for reads, the returned byte. If no valid sync code arrives in three straight cycles, the engine abandons the cycle and reports an error. A new request presented in the final turnaround cycle puts its start field on the bus in the very next cycle.

Top module: `lpc_mem_host`

## Requirements
- R1: While reset is held and after it is released, the frame strobe is high, the nibble output enable is low, and done and error are low until a request is accepted.
- R2: The cycle after a start request is accepted, the frame strobe is low for exactly one cycle while the host drives nibble 0000. It is high in every other cycle.
- R3: In the cycle after the start nibble, the host drives the cycle-type nibble: 0100 for a read, 0110 for a write.
- R4: In the eight cycles after the cycle type, the host drives the address captured at acceptance, most significant nibble first.
- R5: For a write, the two cycles after the address carry the data byte captured at acceptance, least significant nibble first.
- R6: After the address (read) or the data (write), the host drives 1111 for one cycle and then releases the lines. The output enable stays low through the sync, read data and final turnaround cycles.
- R7: Each sync cycle that carries 0101 or 0110 is a wait. Any number of waits may come before the ending code, and a wait restarts the no-response count.
- R8: For a read ended by sync 0000 or 1010, the two following cycles give the data byte, least significant nibble first. The byte appears on the read-data output together with done.
- R9: Sync code 1010 completes the rest of the cycle as normal, but done comes with the error flag high. The error flag is never high without done.
- R10: Three consecutive sync cycles with a code other than 0000, 0101, 0110 or 1010 abort the cycle. In the next cycle done and error are both high, and the host is idle with the lines released.
- R11: Done is a single-cycle pulse. For a completed cycle it rises in the cycle after the second final turnaround cycle, which is the fifth cycle after the ending sync for a read and the third for a write.
- R12: A start request seen during the second final turnaround cycle starts the next cycle at once, with its start field in the same cycle as done. A start request at any other time while busy is ignored: the captured address and direction do not change, and no extra cycle follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Request strobe; accepted when idle or in the last turnaround cycle |
| reqWrite | input | 1 | 1 = memory write, 0 = memory read |
| reqAddr | input | 32 | Memory address |
| reqWdata | input | 8 | Write data byte |
| reqDone | output | 1 | One-cycle completion pulse |
| reqRdata | output | 8 | Byte returned by the last completed read |
| reqErr | output | 1 | Error or abort status, valid with done |
| frameN | output | 1 | Active-low frame strobe |
| ladOut | output | 4 | Nibble value driven by the host |
| ladOe | output | 1 | Host drives the nibble lines when high |
| ladIn | input | 4 | Nibble value seen on the lines |

## Verification
Two events can fall in one cycle: the done pulse of one transfer and the start field of the next, when a request arrives during the final turnaround. The bench provokes this both in a directed case and at random in the stimulus loop. In that shared cycle it checks that done, the error flag and the returned byte belong to the old transfer while the frame strobe and nibble 0000 belong to the new one. The following cycle type and address nibbles must then match the new request. A second overlap is a request raised in the middle of the address phase. There the bench checks that the address stream continues unchanged and that no extra frame follows done.

// File: rtl/lpc_host_pkg.sv
`timescale 1ns/1ps
package lpc_host_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTYPE, ST_ADDR, ST_WDATA,
    ST_TAR_ONES, ST_TAR_FLOAT, ST_SYNC, ST_RDATA, ST_BACK_A, ST_BACK_B
  } stateT;

  typedef enum logic [2:0] {
    NS_START, NS_CTYPE, NS_ADDR, NS_WDATA, NS_ONES
  } nibSelT;

  typedef enum logic [1:0] {
    SK_READY, SK_WAIT, SK_ERROR, SK_NONE
  } syncKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   shiftAddr;
    logic   shiftData;
    logic   capture;
    logic   drive;
    logic   frame;
    nibSelT nibSel;
    logic   finish;
    logic   finishErr;
  } dpCtlT;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] CT_READ    = 4'h4;
  localparam logic [3:0] CT_WRITE   = 4'h6;
  localparam logic [3:0] NIB_ONES   = 4'hF;
  localparam logic [3:0] SY_READY   = 4'h0;
  localparam logic [3:0] SY_SHORT   = 4'h5;
  localparam logic [3:0] SY_LONG    = 4'h6;
  localparam logic [3:0] SY_ERR     = 4'hA;

  function automatic syncKindT decodeSync(input logic [3:0] v);
    case (v)
      SY_READY:           return SK_READY;
      SY_SHORT, SY_LONG:  return SK_WAIT;
      SY_ERR:             return SK_ERROR;
      default:            return SK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lpc_host_ctrl.sv
`timescale 1ns/1ps
module lpc_host_ctrl
  import lpc_host_pkg::*;
#(
  parameter int ADDR_NIBS  = 8,
  parameter int DATA_NIBS  = 2,
  parameter int SYNC_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       isWrite,
  input  logic [3:0] ladIn,
  output dpCtlT      ctl
);

  localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam int TO_W  = (SYNC_LIMIT > 1) ? $clog2(SYNC_LIMIT) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);
  localparam logic [TO_W-1:0]  TO_LAST   = TO_W'(SYNC_LIMIT - 1);

  stateT            state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [TO_W-1:0]  toCnt, toCntNxt;
  logic             errSeen, errSeenNxt;
  syncKindT         syncKind;

  assign syncKind = decodeSync(ladIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      toCnt   <= '0;
      errSeen <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      toCnt   <= toCntNxt;
      errSeen <= errSeenNxt;
    end
  end

  always_comb begin
    stateNxt   = state;
    cntNxt     = cnt;
    toCntNxt   = toCnt;
    errSeenNxt = errSeen;
    ctl        = '0;
    ctl.nibSel = NS_ONES;

    case (state)
      ST_IDLE: begin
        if (reqStart) begin
          ctl.load = 1'b1;
          stateNxt = ST_START;
        end
      end
      ST_START: begin
        ctl.drive  = 1'b1;
        ctl.frame  = 1'b1;
        ctl.nibSel = NS_START;
        stateNxt   = ST_CTYPE;
      end
      ST_CTYPE: begin
        ctl.drive  = 1'b1;
        ctl.nibSel = NS_CTYPE;
        cntNxt     = '0;
        stateNxt   = ST_ADDR;
      end
      ST_ADDR: begin
        ctl.drive     = 1'b1;
        ctl.nibSel    = NS_ADDR;
        ctl.shiftAddr = 1'b1;
        cntNxt        = cnt + 1'b1;
        if (cnt == ADDR_LAST) begin
          cntNxt   = '0;
          stateNxt = isWrite ? ST_WDATA : ST_TAR_ONES;
        end
      end
      ST_WDATA: begin
        ctl.drive     = 1'b1;
        ctl.nibSel    = NS_WDATA;
        ctl.shiftData = 1'b1;
        cntNxt        = cnt + 1'b1;
        if (cnt == DATA_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_TAR_ONES;
        end
      end
      ST_TAR_ONES: begin
        ctl.drive  = 1'b1;
        ctl.nibSel = NS_ONES;
        stateNxt   = ST_TAR_FLOAT;
      end
      ST_TAR_FLOAT: begin
        toCntNxt   = '0;
        errSeenNxt = 1'b0;
        stateNxt   = ST_SYNC;
      end
      ST_SYNC: begin
        case (syncKind)
          SK_READY, SK_ERROR: begin
            errSeenNxt = (syncKind == SK_ERROR);
            cntNxt     = '0;
            stateNxt   = isWrite ? ST_BACK_A : ST_RDATA;
          end
          SK_WAIT: toCntNxt = '0;
          default: begin
            if (toCnt == TO_LAST) begin
              ctl.finish    = 1'b1;
              ctl.finishErr = 1'b1;
              stateNxt      = ST_IDLE;
            end else begin
              toCntNxt = toCnt + 1'b1;
            end
          end
        endcase
      end
      ST_RDATA: begin
        ctl.capture = 1'b1;
        cntNxt      = cnt + 1'b1;
        if (cnt == DATA_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_BACK_A;
        end
      end
      ST_BACK_A: stateNxt = ST_BACK_B;
      ST_BACK_B: begin
        ctl.finish    = 1'b1;
        ctl.finishErr = errSeen;
        if (reqStart) begin
          ctl.load = 1'b1;
          stateNxt = ST_START;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lpc_host_dp.sv
`timescale 1ns/1ps
module lpc_host_dp
  import lpc_host_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [3:0]        ladIn,
  output logic              isWrite,
  output logic              reqDone,
  output logic              reqErr,
  output logic [DATA_W-1:0] reqRdata,
  output logic              frameN,
  output logic [3:0]        ladOut,
  output logic              ladOe
);

  localparam int DATA_NIBS = DATA_W / 4;
  localparam int PTR_W     = (DATA_NIBS > 1) ? $clog2(DATA_NIBS) : 1;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdQ;
  logic [PTR_W-1:0]  capPtr;
  logic              writeQ;
  logic              doneQ, errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      writeQ <= 1'b0;
      capPtr <= '0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      dataQ  <= reqWdata;
      writeQ <= reqWrite;
      capPtr <= '0;
    end else begin
      if (ctl.shiftAddr) addrQ  <= addrQ << 4;
      if (ctl.shiftData) dataQ  <= dataQ >> 4;
      if (ctl.capture)   capPtr <= capPtr + 1'b1;
    end
  end

  // one capture lane per returned nibble
  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_rdLane
    always_ff @(posedge clk) begin
      if (!rstN)
        rdQ[g*4 +: 4] <= '0;
      else if (ctl.capture && capPtr == PTR_W'(g))
        rdQ[g*4 +: 4] <= ladIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= ctl.finish;
      errQ  <= ctl.finish & ctl.finishErr;
    end
  end

  always_comb begin
    case (ctl.nibSel)
      NS_START: ladOut = NIB_START;
      NS_CTYPE: ladOut = writeQ ? CT_WRITE : CT_READ;
      NS_ADDR:  ladOut = addrQ[ADDR_W-1 -: 4];
      NS_WDATA: ladOut = dataQ[3:0];
      default:  ladOut = NIB_ONES;
    endcase
  end

  assign ladOe    = ctl.drive;
  assign frameN   = ~ctl.frame;
  assign isWrite  = writeQ;
  assign reqDone  = doneQ;
  assign reqErr   = errQ;
  assign reqRdata = rdQ;

endmodule

// File: rtl/lpc_mem_host.sv
`timescale 1ns/1ps
module lpc_mem_host
  import lpc_host_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 8,
  parameter int SYNC_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqDone,
  output logic [DATA_W-1:0] reqRdata,
  output logic              reqErr,
  output logic              frameN,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  input  logic [3:0]        ladIn
);

  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int DATA_NIBS = DATA_W / 4;

  dpCtlT ctl;
  logic  isWrite;

  lpc_host_ctrl #(
    .ADDR_NIBS (ADDR_NIBS),
    .DATA_NIBS (DATA_NIBS),
    .SYNC_LIMIT(SYNC_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqStart(reqStart),
    .isWrite (isWrite),
    .ladIn   (ladIn),
    .ctl     (ctl)
  );

  lpc_host_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .ladIn   (ladIn),
    .isWrite (isWrite),
    .reqDone (reqDone),
    .reqErr  (reqErr),
    .reqRdata(reqRdata),
    .frameN  (frameN),
    .ladOut  (ladOut),
    .ladOe   (ladOe)
  );

endmodule

// File: rtl/lpc_host_checker.sv
`timescale 1ns/1ps
module lpc_host_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqDone,
  input logic       reqErr,
  input logic       frameN,
  input logic [3:0] ladOut,
  input logic       ladOe
);

  // R2: frame only with a driven start nibble
  p_frame_start_nib_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |-> (ladOe && ladOut == 4'h0));

  // R2: frame lasts one cycle
  p_frame_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> frameN);

  // R3: cycle type follows the start nibble
  p_ctype_after_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> (ladOe && (ladOut == 4'h4 || ladOut == 4'h6)));

  // R6: the host lets go of the lines only after driving ones
  p_release_after_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ladOe) |-> $past(ladOut) == 4'hF);

  // R11: done is a single pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  // R9: error only accompanies done
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> reqDone);

endmodule

bind lpc_mem_host lpc_host_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .reqDone(reqDone),
  .reqErr (reqErr),
  .frameN (frameN),
  .ladOut (ladOut),
  .ladOe  (ladOe)
);

// File: tb/sim_lpc_mem_host.sv
`timescale 1ns/1ps
module sim_lpc_mem_host;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqDone;
  logic [7:0]  reqRdata;
  logic        reqErr;
  logic        frameN;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic [3:0]  ladIn = 4'hF;

  always #2.5 clk = ~clk;

  lpc_mem_host u0 (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqDone(reqDone),
    .reqRdata(reqRdata), .reqErr(reqErr), .frameN(frameN),
    .ladOut(ladOut), .ladOe(ladOe), .ladIn(ladIn)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pickInvalid(input int k);
    logic [3:0] v;
    v = 4'(k % 16);
    if (v == 4'h0 || v == 4'h5 || v == 4'h6 || v == 4'hA) v = 4'hF;
    return v;
  endfunction

  function automatic logic [3:0] expCtype(input bit w);
    return w ? 4'h6 : 4'h4;
  endfunction

  // endKind: 0 ready, 1 error sync, 2 no response
  task automatic runXfer(input bit w, input logic [31:0] a, input logic [7:0] wd,
                         input logic [7:0] rd, input int nWait, input int endKind,
                         input bit preStarted, input bit chain, input bit cw,
                         input logic [31:0] ca, input logic [7:0] cwd,
                         input bit probe);
    if (!preStarted) begin
      reqWrite = w; reqAddr = a; reqWdata = wd; reqStart = 1'b1;
      @(negedge clk);
    end
    reqStart = 1'b0;
    check("R2", "frame low in start", 32'(frameN), 0);
    check("R2", "start nibble", 32'(ladOut), 0);
    check("R2", "start driven", 32'(ladOe), 1);
    @(negedge clk);
    check("R3", "cycle type", 32'(ladOut), 32'(expCtype(w)));
    check("R2", "frame high after start", 32'(frameN), 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R4", "address nibble", 32'(ladOut), 32'(a[31-4*i -: 4]));
      if (probe && i == 2) begin
        reqStart = 1'b1; reqAddr = ~a; reqWrite = ~w;
      end else begin
        reqStart = 1'b0;
      end
    end
    reqStart = 1'b0;
    if (w) begin
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        check("R5", "write nibble", 32'(ladOut), 32'(wd[4*i +: 4]));
      end
    end
    @(negedge clk);
    check("R6", "turnaround ones", 32'(ladOut), 32'hF);
    check("R6", "turnaround driven", 32'(ladOe), 1);
    @(negedge clk);
    check("R6", "turnaround released", 32'(ladOe), 0);
    for (int k = 0; k < nWait; k++) begin
      @(negedge clk);
      if (k % 3 == 1 && k != nWait - 1) ladIn = pickInvalid(k + 1);
      else ladIn = (k % 2 == 1) ? 4'h5 : 4'h6;
      check("R7", "no drive while waiting", 32'(ladOe), 0);
      check("R7", "no done while waiting", 32'(reqDone), 0);
    end
    if (endKind == 2) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        ladIn = pickInvalid(k + 7);
      end
      @(negedge clk);
      ladIn = 4'hF;
      check("R10", "abort done", 32'(reqDone), 1);
      check("R10", "abort error", 32'(reqErr), 1);
      check("R10", "abort released", 32'(ladOe), 0);
      @(negedge clk);
      check("R10", "idle after abort", 32'(frameN), 1);
      check("R11", "done single after abort", 32'(reqDone), 0);
      return;
    end
    @(negedge clk);
    ladIn = (endKind == 1) ? 4'hA : 4'h0;
    if (!w) begin
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        ladIn = rd[4*i +: 4];
      end
    end
    @(negedge clk);
    ladIn = 4'hF;
    check("R6", "released in back turnaround", 32'(ladOe), 0);
    @(negedge clk);
    check("R11", "no early done", 32'(reqDone), 0);
    check("R6", "released in last turnaround", 32'(ladOe), 0);
    if (chain) begin
      reqWrite = cw; reqAddr = ca; reqWdata = cwd; reqStart = 1'b1;
    end
    @(negedge clk);
    check("R11", "done pulse", 32'(reqDone), 1);
    check("R9", "error flag", 32'(reqErr), 32'(endKind == 1));
    if (!w) check("R8", "read byte", 32'(reqRdata), 32'(rd));
    if (chain) check("R12", "chained start with done", 32'(frameN), 0);
    if (probe) begin
      @(negedge clk);
      check("R12", "ignored request left no frame", 32'(frameN), 1);
      check("R11", "done single", 32'(reqDone), 0);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    bit          pend, chain, cw, w;
    logic [31:0] a, ca;
    logic [7:0]  wd, cwd, rd;
    int          nWait, endKind;
    void'($urandom(32'h1f2e3d4c));
    repeat (4) @(negedge clk);
    check("R1", "frame idle in reset", 32'(frameN), 1);
    check("R1", "oe idle in reset", 32'(ladOe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "frame idle", 32'(frameN), 1);
    check("R1", "oe idle", 32'(ladOe), 0);
    check("R1", "done idle", 32'(reqDone), 0);
    check("R1", "err idle", 32'(reqErr), 0);

    // directed corner cases
    runXfer(0, 32'h1234_5678, 8'h00, 8'hA5, 0, 0, 0, 0, 0, 0, 0, 0);
    runXfer(1, 32'hFEDC_BA98, 8'h3C, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    runXfer(0, 32'h0000_00FF, 8'h00, 8'h5A, 4, 1, 0, 0, 0, 0, 0, 0);
    runXfer(1, 32'h8000_0001, 8'hE7, 8'h00, 0, 2, 0, 0, 0, 0, 0, 0);
    runXfer(0, 32'hCAFE_0000, 8'h00, 8'h81, 8, 0, 0, 0, 0, 0, 0, 0);
    runXfer(1, 32'h0F0F_F0F0, 8'h96, 8'h00, 5, 1, 0, 0, 0, 0, 0, 0);
    runXfer(0, 32'h2468_ACE0, 8'h00, 8'h42, 2, 0, 0, 1, 1, 32'h1357_9BDF, 8'hC3, 0);
    runXfer(1, 32'h1357_9BDF, 8'hC3, 8'h00, 1, 0, 1, 0, 0, 0, 0, 0);
    runXfer(1, 32'h7654_3210, 8'h11, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1);
    runXfer(0, 32'h5555_AAAA, 8'h00, 8'h7E, 3, 2, 0, 0, 0, 0, 0, 1);

    // constrained random mix
    pend = 1'b0;
    w = 1'b0; a = '0; wd = '0;
    for (int it = 0; it < 60; it++) begin
      if (!pend) begin
        w = 1'($urandom_range(0, 1));
        a = $urandom();
        wd = 8'($urandom());
      end
      rd = 8'($urandom());
      nWait = $urandom_range(0, 9);
      endKind = ($urandom_range(0, 5) == 0) ? 2 : int'($urandom_range(0, 1));
      chain = (endKind != 2) && (it != 59) && ($urandom_range(0, 1) == 1);
      cw = 1'($urandom_range(0, 1));
      ca = $urandom();
      cwd = 8'($urandom());
      runXfer(w, a, wd, rd, nWait, endKind, pend, chain, cw, ca, cwd, 0);
      pend = chain;
      if (chain) begin
        w = cw; a = ca; wd = cwd;
      end
    end
    repeat (3) @(negedge clk);
    check("R1", "idle at end", 32'(frameN), 1);
    finishRun();
  end

endmodule